// File: doc/BRIEF.md
# Timed-Event Bus Command Initiator

This block sits between a local request port and a shared bus that carries timestamped events. A local client asks for one of three operations: a timed write, a timed read, or a query of how many writes the selected target can take without waiting. The initiator captures the request and turns it into a short sequence on the bus. In the first cycle it drives the destination/channel selector and the event timestamp with the command held at nop. In the next cycle it pulses the command for exactly one clock, together with the data, address and input timeout. After that it polls the status that the target returns.

On a write it polls until the output wait flag drops. On a read it polls until the wait-for-status flag drops. On a buffer-space query it polls until the target flags the count as valid. The block then pulses `done` together with an error code, and for reads and space queries it keeps the returned values. A watchdog limits how long polling may last, so a silent target cannot lock the initiator. New requests are ignored while a transaction is in flight.

Top module: `tev_initiator`

## Requirements
- R1: `bus_cmd` uses the codes 0 = nop, 1 = write, 2 = read and 3 = buffer-space query. It is nop on every cycle except a single cycle for each accepted request, where it carries that request's kind.
- R2: An accepted request (`req_valid` high, `req_kind` not 0, `busy` low at a clock edge) first gives a setup cycle. In the setup cycle `bus_chan` and `bus_otime` carry the request and `bus_cmd` is nop. The cycle after it is the issue cycle. From the setup cycle until completion, `bus_chan`, `bus_otime`, `bus_odata`, `bus_oaddr` and `bus_itimeout` hold the accepted values.
- R3: `bus_chan` is the 24-bit selector, passed through unchanged. Bits 23:16 name the destination and bits 15:0 name the channel within it.
- R4: Write completion. Each clock edge after the issue cycle samples `bus_ostatus`. While bit 0 (wait) is set, polling continues. `done` goes high in the cycle after the first sample with bit 0 clear. `err_code` is then 2 if bit 2 (unreachable) is set, else 1 if bit 1 (underflow) is set, else 0.
- R5: Read completion. The block polls while `bus_istatus` bit 2 (wait for status) is set and completes as in R4. `err_code` is 2 if bit 3 (unreachable) is set, else 4 if bit 1 (overflow) is set, else 3 if bit 0 (timeout) is set, else 0. Overflow therefore wins over timeout.
- R6: A read that completes without a watchdog expiry loads `bus_idata` into `rsp_data` and `bus_itime` into `rsp_time`. Both values are taken at the completing sample, and both hold until the next such read.
- R7: A buffer-space query polls while `bus_space_valid` is low. It completes with `err_code` 0 and loads the 16-bit `bus_space` into `rsp_space`, where it holds until the next such query.
- R8: If POLL_LIMIT consecutive samples all show the wait condition, the transaction ends with `done` and `err_code` 5 and no response register changes. With POLL_LIMIT-1 waiting samples, the transaction still completes normally.
- R9: `busy` is high from the setup cycle through the last poll cycle and is low in the `done` cycle. A request presented while `busy` is high, or with `req_kind` 0, is ignored.
- R10: After reset `busy`, `done`, `bus_cmd` and all response registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Request kind, same codes as `bus_cmd` (0 ignored) |
| req_chan | input | 24 | Destination (23:16) and channel (15:0) |
| req_time | input | TS_W | Event timestamp |
| req_data | input | OD_W | Write data |
| req_addr | input | AD_W | Write address |
| req_timeout | input | TS_W | Timestamp at which a read gives up |
| busy | output | 1 | Transaction in flight |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result: 0 ok, 1 underflow, 2 unreachable, 3 timeout, 4 overflow, 5 hang |
| rsp_data | output | ID_W | Data from the last read |
| rsp_time | output | TS_W | Timestamp from the last read |
| rsp_space | output | SP_W | Count from the last buffer-space query |
| bus_cmd | output | 2 | Bus command |
| bus_chan | output | 24 | Bus channel selector |
| bus_otime | output | TS_W | Bus output timestamp |
| bus_odata | output | OD_W | Bus output data |
| bus_oaddr | output | AD_W | Bus output address |
| bus_itimeout | output | TS_W | Bus input timeout |
| bus_ostatus | input | 3 | Output status: wait, underflow, unreachable (bits 0..2) |
| bus_space_valid | input | 1 | Buffer-space count valid |
| bus_space | input | SP_W | Buffer-space count |
| bus_istatus | input | 4 | Input status: timeout, overflow, wait, unreachable (bits 0..3) |
| bus_idata | input | ID_W | Returned read data |
| bus_itime | input | TS_W | Returned read timestamp |

## Verification
The bench keeps the default widths and sets POLL_LIMIT to 6. With that limit, watchdog expiry on writes and reads fits into a few cycles, and so does the boundary case of five waiting samples that still complete. A scripted target holds its wait flag for a chosen number of samples and then presents chosen status bits. This covers every error-priority combination, zero and non-zero wait lengths, and requests held through a busy transaction.

// File: rtl/tev_pkg.sv
package tev_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_SPACE = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_UNDERFLOW = 3'd1,
    ERR_UNREACH   = 3'd2,
    ERR_TIMEOUT   = 3'd3,
    ERR_OVERFLOW  = 3'd4,
    ERR_HANG      = 3'd5
  } err_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ISSUE,
    ST_POLL
  } st_e;

  // output status bit positions
  localparam int OST_WAIT    = 0;
  localparam int OST_UNDER   = 1;
  localparam int OST_UNREACH = 2;

  // input status bit positions
  localparam int IST_TIMEOUT = 0;
  localparam int IST_OVER    = 1;
  localparam int IST_WAIT    = 2;
  localparam int IST_UNREACH = 3;

endpackage

// File: rtl/tev_status_decode.sv
module tev_status_decode
  import tev_pkg::*;
(
  input  cmd_e       kind,
  input  logic [2:0] ostatus,
  input  logic [3:0] istatus,
  input  logic       space_valid,
  output logic       waiting,
  output err_e       status_err
);

  always_comb begin
    waiting    = 1'b0;
    status_err = ERR_NONE;
    case (kind)
      CMD_WRITE: begin
        waiting = ostatus[OST_WAIT];
        if (ostatus[OST_UNREACH])    status_err = ERR_UNREACH;
        else if (ostatus[OST_UNDER]) status_err = ERR_UNDERFLOW;
      end
      CMD_READ: begin
        waiting = istatus[IST_WAIT];
        if (istatus[IST_UNREACH])      status_err = ERR_UNREACH;
        else if (istatus[IST_OVER])    status_err = ERR_OVERFLOW;
        else if (istatus[IST_TIMEOUT]) status_err = ERR_TIMEOUT;
      end
      CMD_SPACE: begin
        waiting = ~space_valid;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tev_seq.sv
module tev_seq
  import tev_pkg::*;
#(
  parameter int POLL_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic waiting,
  input  err_e status_err,
  output st_e  state,
  output logic finish_ok,
  output logic done,
  output err_e err_code
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POLL_LIMIT - 1);

  st_e              state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  err_e             err_q, err_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    done_d    = 1'b0;
    err_d     = err_q;
    finish_ok = 1'b0;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_SETUP;
      ST_SETUP: state_d = ST_ISSUE;
      ST_ISSUE: begin
        state_d = ST_POLL;
        cnt_d   = '0;
      end
      ST_POLL: begin
        if (!waiting) begin
          done_d    = 1'b1;
          err_d     = status_err;
          finish_ok = 1'b1;
          state_d   = ST_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          done_d  = 1'b1;
          err_d   = ERR_HANG;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign state    = state_q;
  assign done     = done_q;
  assign err_code = err_q;

endmodule

// File: rtl/tev_capture.sv
module tev_capture #(
  parameter int ID_W = 32,
  parameter int TS_W = 64,
  parameter int SP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_read,
  input  logic            cap_space,
  input  logic [ID_W-1:0] idata,
  input  logic [TS_W-1:0] itime,
  input  logic [SP_W-1:0] space,
  output logic [ID_W-1:0] rsp_data,
  output logic [TS_W-1:0] rsp_time,
  output logic [SP_W-1:0] rsp_space
);

  logic [ID_W-1:0] data_q, data_d;
  logic [TS_W-1:0] time_q, time_d;
  logic [SP_W-1:0] space_q, space_d;

  always_comb begin
    data_d  = cap_read  ? idata : data_q;
    time_d  = cap_read  ? itime : time_q;
    space_d = cap_space ? space : space_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      time_q  <= '0;
      space_q <= '0;
    end else begin
      data_q  <= data_d;
      time_q  <= time_d;
      space_q <= space_d;
    end
  end

  assign rsp_data  = data_q;
  assign rsp_time  = time_q;
  assign rsp_space = space_q;

endmodule

// File: rtl/tev_initiator.sv
module tev_initiator
  import tev_pkg::*;
#(
  parameter int DEST_W     = 8,
  parameter int CHN_W      = 16,
  parameter int TS_W       = 64,
  parameter int OD_W       = 32,
  parameter int AD_W       = 8,
  parameter int ID_W       = 32,
  parameter int SP_W       = 16,
  parameter int POLL_LIMIT = 1000,
  localparam int SEL_W     = DEST_W + CHN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [SEL_W-1:0] req_chan,
  input  logic [TS_W-1:0]  req_time,
  input  logic [OD_W-1:0]  req_data,
  input  logic [AD_W-1:0]  req_addr,
  input  logic [TS_W-1:0]  req_timeout,
  output logic             busy,
  output logic             done,
  output logic [2:0]       err_code,
  output logic [ID_W-1:0]  rsp_data,
  output logic [TS_W-1:0]  rsp_time,
  output logic [SP_W-1:0]  rsp_space,
  output logic [1:0]       bus_cmd,
  output logic [SEL_W-1:0] bus_chan,
  output logic [TS_W-1:0]  bus_otime,
  output logic [OD_W-1:0]  bus_odata,
  output logic [AD_W-1:0]  bus_oaddr,
  output logic [TS_W-1:0]  bus_itimeout,
  input  logic [2:0]       bus_ostatus,
  input  logic             bus_space_valid,
  input  logic [SP_W-1:0]  bus_space,
  input  logic [3:0]       bus_istatus,
  input  logic [ID_W-1:0]  bus_idata,
  input  logic [TS_W-1:0]  bus_itime
);

  st_e  state;
  logic accept, waiting, finish_ok;
  err_e status_err, err_q;

  cmd_e             kind_q, kind_d;
  logic [SEL_W-1:0] chan_q, chan_d;
  logic [TS_W-1:0]  otime_q, otime_d;
  logic [OD_W-1:0]  odata_q, odata_d;
  logic [AD_W-1:0]  oaddr_q, oaddr_d;
  logic [TS_W-1:0]  itmo_q, itmo_d;

  assign accept = req_valid && (req_kind != 2'd0) && (state == ST_IDLE);

  // request holding registers, loaded only on acceptance
  always_comb begin
    kind_d  = kind_q;
    chan_d  = chan_q;
    otime_d = otime_q;
    odata_d = odata_q;
    oaddr_d = oaddr_q;
    itmo_d  = itmo_q;
    if (accept) begin
      kind_d  = cmd_e'(req_kind);
      chan_d  = req_chan;
      otime_d = req_time;
      odata_d = req_data;
      oaddr_d = req_addr;
      itmo_d  = req_timeout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= CMD_NOP;
      chan_q  <= '0;
      otime_q <= '0;
      odata_q <= '0;
      oaddr_q <= '0;
      itmo_q  <= '0;
    end else begin
      kind_q  <= kind_d;
      chan_q  <= chan_d;
      otime_q <= otime_d;
      odata_q <= odata_d;
      oaddr_q <= oaddr_d;
      itmo_q  <= itmo_d;
    end
  end

  tev_status_decode u_decode (
    .kind        (kind_q),
    .ostatus     (bus_ostatus),
    .istatus     (bus_istatus),
    .space_valid (bus_space_valid),
    .waiting     (waiting),
    .status_err  (status_err)
  );

  tev_seq #(.POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .waiting    (waiting),
    .status_err (status_err),
    .state      (state),
    .finish_ok  (finish_ok),
    .done       (done),
    .err_code   (err_q)
  );

  tev_capture #(.ID_W(ID_W), .TS_W(TS_W), .SP_W(SP_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_read  (finish_ok && (kind_q == CMD_READ)),
    .cap_space (finish_ok && (kind_q == CMD_SPACE)),
    .idata     (bus_idata),
    .itime     (bus_itime),
    .space     (bus_space),
    .rsp_data  (rsp_data),
    .rsp_time  (rsp_time),
    .rsp_space (rsp_space)
  );

  assign busy         = (state != ST_IDLE);
  assign err_code     = err_q;
  assign bus_cmd      = (state == ST_ISSUE) ? kind_q : CMD_NOP;
  assign bus_chan     = chan_q;
  assign bus_otime    = otime_q;
  assign bus_odata    = odata_q;
  assign bus_oaddr    = oaddr_q;
  assign bus_itimeout = itmo_q;

endmodule

// File: rtl/tev_initiator_chk.sv
module tev_initiator_chk #(
  parameter int TS_W  = 64,
  parameter int SEL_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic [2:0]       err_code,
  input logic [1:0]       bus_cmd,
  input logic [SEL_W-1:0] bus_chan,
  input logic [TS_W-1:0]  bus_otime,
  input logic [2:0]       bus_ostatus,
  input logic [3:0]       bus_istatus
);

  logic [1:0] cur_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cur_kind <= 2'd0;
    else if (bus_cmd != 2'd0) cur_kind <= bus_cmd;
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |=> (bus_cmd == 2'd0));

  a_r1_nop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_cmd == 2'd0));

  a_r2_setup_before_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |-> ($past(busy) && $stable(bus_chan) && $stable(bus_otime)));

  a_r4_no_done_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_kind == 2'd1 && err_code != 3'd5) |-> !$past(bus_ostatus[0]));

  a_r5_overflow_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_kind == 2'd2 &&
     $past(!bus_istatus[2] && bus_istatus[1] && !bus_istatus[3])) |-> (err_code == 3'd4));

  a_r8_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code <= 3'd5));

  a_r9_ignore_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(bus_chan));

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

bind tev_initiator tev_initiator_chk #(.TS_W(TS_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tev_initiator_test.sv
module tev_initiator_test;

  localparam int LIM = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [23:0] req_chan;
  logic [63:0] req_time;
  logic [31:0] req_data;
  logic [7:0]  req_addr;
  logic [63:0] req_timeout;
  logic        busy, done;
  logic [2:0]  err_code;
  logic [31:0] rsp_data;
  logic [63:0] rsp_time;
  logic [15:0] rsp_space;
  logic [1:0]  bus_cmd;
  logic [23:0] bus_chan;
  logic [63:0] bus_otime;
  logic [31:0] bus_odata;
  logic [7:0]  bus_oaddr;
  logic [63:0] bus_itimeout;
  logic [2:0]  bus_ostatus;
  logic        bus_space_valid;
  logic [15:0] bus_space;
  logic [3:0]  bus_istatus;
  logic [31:0] bus_idata;
  logic [63:0] bus_itime;

  always #5 clk = ~clk;

  tev_initiator #(.POLL_LIMIT(LIM)) uut (.*);

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int          m_phase = 0;
  int          m_polls = 0;
  int          m_kind = 0;
  logic [23:0] m_chan = '0;
  logic [63:0] m_time = '0, m_tmo = '0;
  logic [31:0] m_data = '0;
  logic [7:0]  m_addr = '0;
  logic        e_done = 1'b0;
  int          e_err = 0;
  logic [31:0] e_rdata = '0;
  logic [63:0] e_rtime = '0;
  logic [15:0] e_space = '0;

  // scripted target
  int          t_wait = 0;
  int          t_rem = 0;
  logic        t_active = 1'b0;
  logic [2:0]  t_ost = '0;
  logic [3:0]  t_ist = '0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic w;
    e_done = 1'b0;
    if (m_phase == 0) begin
      if (req_valid && req_kind != 2'd0) begin
        m_kind = req_kind; m_chan = req_chan; m_time = req_time;
        m_data = req_data; m_addr = req_addr; m_tmo = req_timeout;
        m_phase = 1;
      end
    end else if (m_phase == 1) begin
      m_phase = 2;
    end else if (m_phase == 2) begin
      m_phase = 3; m_polls = 0;
    end else begin
      if (m_kind == 1)      w = bus_ostatus[0];
      else if (m_kind == 2) w = bus_istatus[2];
      else                  w = !bus_space_valid;
      if (!w) begin
        e_done = 1'b1; m_phase = 0; e_err = 0;
        if (m_kind == 1) begin
          if (bus_ostatus[2]) e_err = 2;
          else if (bus_ostatus[1]) e_err = 1;
        end else if (m_kind == 2) begin
          if (bus_istatus[3]) e_err = 2;
          else if (bus_istatus[1]) e_err = 4;
          else if (bus_istatus[0]) e_err = 3;
          e_rdata = bus_idata; e_rtime = bus_itime;
        end else begin
          e_space = bus_space;
        end
      end else if (m_polls == LIM - 1) begin
        e_done = 1'b1; e_err = 5; m_phase = 0;
      end else begin
        m_polls++;
      end
    end
  endtask

  task automatic compare();
    string rq;
    chk("R9", "busy", busy, m_phase != 0);
    chk("R1", "bus_cmd", bus_cmd, (m_phase == 2) ? m_kind : 0);
    if (m_phase != 0) begin
      chk("R3", "bus_chan", bus_chan, m_chan);
      chk("R2", "bus_otime", bus_otime, m_time);
      chk("R2", "bus_odata", bus_odata, m_data);
      chk("R2", "bus_oaddr", bus_oaddr, m_addr);
      chk("R2", "bus_itimeout", bus_itimeout, m_tmo);
    end
    chk("R4", "done", done, e_done);
    if (e_done) begin
      if (e_err == 5)       rq = "R8";
      else if (m_kind == 1) rq = "R4";
      else if (m_kind == 2) rq = "R5";
      else                  rq = "R7";
      chk(rq, "err_code", err_code, e_err);
    end
    chk("R6", "rsp_data", rsp_data, e_rdata);
    chk("R6", "rsp_time", rsp_time, e_rtime);
    chk("R7", "rsp_space", rsp_space, e_space);
  endtask

  task automatic target_update();
    if (done) t_active = 1'b0;
    if (bus_cmd != 2'd0) begin t_active = 1'b1; t_rem = t_wait; end
    if (t_active) begin
      bus_ostatus     = {t_ost[2:1], t_rem > 0};
      bus_istatus     = {t_ist[3], t_rem > 0, t_ist[1:0]};
      bus_space_valid = (t_rem == 0);
      if (t_rem > 0) t_rem--;
    end else begin
      bus_ostatus = '0; bus_istatus = '0; bus_space_valid = 1'b0;
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
    target_update();
  endtask

  task automatic run(input logic [1:0] kind, input logic [23:0] chan, input int wait_n,
                     input logic [2:0] ost, input logic [3:0] ist, input logic hold);
    t_wait = wait_n; t_ost = ost; t_ist = ist;
    bus_idata = $urandom; bus_itime = {$urandom, $urandom}; bus_space = 16'($urandom);
    req_valid = 1'b1; req_kind = kind; req_chan = chan;
    req_time = {$urandom, $urandom}; req_data = $urandom;
    req_addr = 8'($urandom); req_timeout = {$urandom, $urandom};
    tick();
    req_valid = hold;
    if (hold) begin req_chan = ~chan; req_kind = 2'd1; end
    for (int i = 0; i < 50 && m_phase != 0; i++) tick();
    req_valid = 1'b0;
    tick();
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_chan = '0; req_time = '0;
    req_data = '0; req_addr = '0; req_timeout = '0; bus_ostatus = '0;
    bus_space_valid = 1'b0; bus_space = '0; bus_istatus = '0; bus_idata = '0; bus_itime = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "busy", busy, 0);
    chk("R10", "done", done, 0);
    chk("R10", "bus_cmd", bus_cmd, 0);
    chk("R10", "rsp_data", rsp_data, 0);
    chk("R10", "rsp_space", rsp_space, 0);
    rst_n = 1'b1;
    tick();
    // R4: writes with various waits and status
    run(2'd1, 24'h12_3456, 0, 3'b000, 4'h0, 1'b0);
    run(2'd1, 24'h01_0002, 3, 3'b010, 4'h0, 1'b0);
    run(2'd1, 24'hFF_FFFF, 1, 3'b110, 4'h0, 1'b0);
    // R5/R6: reads
    run(2'd2, 24'h03_0010, 2, 3'b000, 4'b0000, 1'b0);
    run(2'd2, 24'h03_0011, 0, 3'b000, 4'b0011, 1'b0);
    run(2'd2, 24'h03_0012, 1, 3'b000, 4'b0001, 1'b0);
    run(2'd2, 24'h03_0013, 0, 3'b000, 4'b1011, 1'b0);
    // R7: buffer-space queries
    run(2'd3, 24'h05_0000, 4, 3'b000, 4'h0, 1'b0);
    run(2'd3, 24'h05_0001, 0, 3'b000, 4'h0, 1'b0);
    // R8: watchdog expiry and boundary
    run(2'd1, 24'h07_0001, 100, 3'b000, 4'h0, 1'b0);
    run(2'd2, 24'h07_0002, 100, 3'b000, 4'h0, 1'b0);
    run(2'd3, 24'h07_0003, LIM - 1, 3'b000, 4'h0, 1'b0);
    run(2'd3, 24'h07_0004, LIM, 3'b000, 4'h0, 1'b0);
    // R9: request held while busy is ignored
    run(2'd2, 24'h09_0009, 2, 3'b000, 4'h0, 1'b1);
    // R9: kind 0 is ignored
    req_valid = 1'b1; req_kind = 2'd0; req_chan = 24'hAA_AAAA;
    for (int i = 0; i < 4; i++) tick();
    req_valid = 1'b0;
    tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule